// File: doc/BRIEF.md
# Multi-Master Region Permission Checker

This block decides, for every bus access, whether it may proceed. It holds no descriptors itself: a set of memory region descriptors is presented on its inputs, each giving an address window, a valid bit, an access-rights word and a process identifier with a mask. An access is described by its address, the number of the master that issues it (0 to 7), its kind (read, write or execute), whether it runs in supervisor or user mode, a process identifier and the slave port it targets. The block answers in the same cycle with a grant, and on a refusal it keeps a record of the fault for the targeted port.

Masters are split into two classes. The lower four carry a full rights field per region: a three-bit user code, a two-bit supervisor code and a flag that makes the region also compare process identifiers. The upper four carry only a read bit and a write bit and can never execute. Where several windows cover the same address, one permissive window suffices. Refused accesses are sorted into three classes: nothing matched, one window matched but refused, or several matched and all refused.

Top module: `region_guard`

## Requirements
- R1: A region's lower bound is taken with its five low address bits forced to 0 and its upper bound with its five low bits forced to 1; both bounds are inclusive.
- R2: For masters 0 to 3 in user mode the 3-bit user code applies: bit 2 allows read, bit 1 allows write, bit 0 allows execute. The region rights word holds this master's field in bits [6m+5:6m], with the user code in [2:0], the supervisor code in [4:3] and the process-identifier flag in [5].
- R3: For masters 0 to 3 in supervisor mode the 2-bit supervisor code applies: 0 allows all three kinds, 1 allows read and execute, 2 allows read and write, 3 falls back to the user code.
- R4: For masters 4 to 7 the rights word bits [24+2(m-4)+1 : 24+2(m-4)] hold write (upper) and read (lower) enables; execute is always refused and the mode has no effect. Access kind encoding: 0 read, 1 write, 2 execute.
- R5: For masters 0 to 3 with the process-identifier flag set, a region matches only if the access identifier equals the region identifier on every bit that is clear in the region mask.
- R6: A region whose valid bit is clear never matches.
- R7: When several regions match, the access is granted if any of them allows it.
- R8: With the global enable clear every valid access is granted and no fault is recorded.
- R9: With the global enable set, an access that matches no region is refused.
- R10: On the clock edge that ends a refused access, the targeted port records the master, the address, a write flag (1 for write, 0 for read or execute) and an attribute of 0 user instruction, 1 user data, 2 supervisor instruction, 3 supervisor data (execute counts as instruction).
- R11: The recorded class is 0 when no region matched, 1 when exactly one matched, 2 when more than one matched.
- R12: Every port flag is 0 after reset. The first fault on a port is held and later faults leave it unchanged; a one on that port's clear input drops the flag on the next edge and takes priority over a fault in the same cycle.
- R13: Each port records only faults aimed at it; a port number at or above the port count records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global checking enable |
| rgn_valid | input | NREG | Per-region valid bit |
| rgn_lo | input | NREG*AW | Region lower bounds, region r at [r*AW +: AW] |
| rgn_hi | input | NREG*AW | Region upper bounds |
| rgn_perm | input | NREG*32 | Region rights words |
| rgn_pid | input | NREG*PIDW | Region process identifiers |
| rgn_pmask | input | NREG*PIDW | Region identifier masks (1 = ignore bit) |
| acc_vld | input | 1 | Access present |
| acc_addr | input | AW | Access address |
| acc_mst | input | 3 | Issuing master |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved and never allowed |
| acc_sup | input | 1 | 1 supervisor mode, 0 user mode |
| acc_pid | input | PIDW | Access process identifier |
| acc_port | input | PORTW | Targeted slave port |
| grant | output | 1 | Access allowed (same cycle) |
| err_clr | input | NPORT | Write-one-to-clear per port |
| err_flag | output | NPORT | Fault held per port |
| err_mst | output | NPORT*3 | Recorded master |
| err_addr | output | NPORT*AW | Recorded address |
| err_wr | output | NPORT | Recorded write flag |
| err_attr | output | NPORT*2 | Recorded mode/kind attribute |
| err_cls | output | NPORT*2 | Recorded fault class |

## Verification
The assertions assume that the access and descriptor inputs are steady through the clock edge that ends an access and that the reserved kind code 3 is never driven. The stimulus applies every access half a period ahead of the edge, keeps the kind within 0 to 2, and during the rights sweeps aims accesses at a port number beyond the port count so that capture state stays untouched until the capture tests clear and exercise it deliberately.

// File: rtl/region_guard_pkg.sv
// Package: shared encodings and helpers for the region permission checker.
// Assumes eight masters, the lower four with full rights fields.
package region_guard_pkg;
    localparam int PRIV_MST  = 4;   // masters with user/supervisor fields
    localparam int PRIV_FLD  = 6;   // bits per privileged field
    localparam int PLAIN_MST = 4;   // masters with read/write bits only
    localparam int PLAIN_FLD = 2;
    localparam int PLAIN_OFS = PRIV_MST * PRIV_FLD;
    localparam int PERM_W    = PLAIN_OFS + PLAIN_MST * PLAIN_FLD;
    localparam int ALIGN_B   = 5;   // region granule is 2**ALIGN_B bytes
    localparam int MST_W     = 3;

    typedef enum logic [1:0] {
        KIND_RD = 2'd0,
        KIND_WR = 2'd1,
        KIND_EX = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_NOHIT   = 2'd0,
        CLS_SINGLE  = 2'd1,
        CLS_OVERLAP = 2'd2
    } err_cls_e;

    // Map a supervisor code to {read, write, execute}; code 3 defers to user.
    function automatic logic [2:0] sup_rights(input logic [1:0] code,
                                              input logic [2:0] user);
        case (code)
            2'd0:    return 3'b111;
            2'd1:    return 3'b101;
            2'd2:    return 3'b110;
            default: return user;
        endcase
    endfunction
endpackage

// File: rtl/region_match.sv
// Module: one region descriptor evaluated against the current access.
// Produces a match flag and an allow flag (allow implies match).
// Assumes the rights word layout from region_guard_pkg.
module region_match
    import region_guard_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PIDW = 8
) (
    input  logic              valid_i,
    input  logic [AW-1:0]     lo_i,
    input  logic [AW-1:0]     hi_i,
    input  logic [PERM_W-1:0] perm_i,
    input  logic [PIDW-1:0]   pid_i,
    input  logic [PIDW-1:0]   pmask_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [MST_W-1:0]  mst_i,
    input  logic [1:0]        kind_i,
    input  logic              sup_i,
    input  logic [PIDW-1:0]   apid_i,
    output logic              hit_o,
    output logic              allow_o
);
    logic [AW-1:0]        lo_eff, hi_eff;
    logic [PRIV_FLD-1:0]  pf [PRIV_MST];
    logic [PLAIN_FLD-1:0] nf [PLAIN_MST];
    logic [PRIV_FLD-1:0]  fld;
    logic [PLAIN_FLD-1:0] rw;
    logic                 priv, pid_ok;
    logic [2:0]           eff;
    logic                 ok_priv, ok_plain;

    // Align bounds to the granule and split the rights word per master.
    always_comb begin
        lo_eff = {lo_i[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
        hi_eff = {hi_i[AW-1:ALIGN_B], {ALIGN_B{1'b1}}};
        for (int i = 0; i < PRIV_MST; i++)
            pf[i] = perm_i[i*PRIV_FLD +: PRIV_FLD];
        for (int i = 0; i < PLAIN_MST; i++)
            nf[i] = perm_i[PLAIN_OFS + i*PLAIN_FLD +: PLAIN_FLD];
    end

    // Select this master's field, then decide match and rights.
    always_comb begin
        priv   = ~mst_i[2];
        fld    = pf[mst_i[1:0]];
        rw     = nf[mst_i[1:0]];
        pid_ok = ~(priv & fld[5]) | (((apid_i ^ pid_i) & ~pmask_i) == '0);
        hit_o  = valid_i & (addr_i >= lo_eff) & (addr_i <= hi_eff) & pid_ok;
        eff    = sup_i ? sup_rights(fld[4:3], fld[2:0]) : fld[2:0];
        case (kind_i)
            KIND_RD: begin ok_priv = eff[2]; ok_plain = rw[0]; end
            KIND_WR: begin ok_priv = eff[1]; ok_plain = rw[1]; end
            KIND_EX: begin ok_priv = eff[0]; ok_plain = 1'b0;  end
            default: begin ok_priv = 1'b0;   ok_plain = 1'b0;  end
        endcase
        allow_o = hit_o & (priv ? ok_priv : ok_plain);
    end
endmodule

// File: rtl/fault_slot.sv
// Module: fault record for one slave port. Holds the first fault until
// a clear pulse; clear wins over a fault in the same cycle.
// Assumes evt_i is a single-cycle qualified refusal aimed at this port.
module fault_slot
    import region_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             clr_i,
    input  logic [MST_W-1:0] mst_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_i,
    input  logic [1:0]       attr_i,
    input  logic [1:0]       cls_i,
    output logic             flag_o,
    output logic [MST_W-1:0] mst_o,
    output logic [AW-1:0]    addr_o,
    output logic             wr_o,
    output logic [1:0]       attr_o,
    output logic [1:0]       cls_o
);
    // Capture the first fault; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            mst_o  <= '0;
            addr_o <= '0;
            wr_o   <= 1'b0;
            attr_o <= '0;
            cls_o  <= '0;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end else if (evt_i && !flag_o) begin
            flag_o <= 1'b1;
            mst_o  <= mst_i;
            addr_o <= addr_i;
            wr_o   <= wr_i;
            attr_o <= attr_i;
            cls_o  <= cls_i;
        end
    end

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o && $stable(addr_o) && $stable(mst_o) && $stable(cls_o));
    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);
    // R10
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !flag_o && !clr_i |=> flag_o && addr_o == $past(addr_i) && wr_o == $past(wr_i));
    // R11
    cls_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> cls_o != 2'd3);
endmodule

// File: rtl/region_guard.sv
// Module: top of the region permission checker. Evaluates all regions in
// parallel, merges their verdicts, classifies refusals and routes them to
// the per-port fault slots. Grant is combinational from the inputs.
// Assumes inputs are steady across the edge that ends an access.
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int AW    = 32,
    parameter int PIDW  = 8,
    parameter int NPORT = 5,
    localparam int PORTW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glb_en,
    input  logic [NREG-1:0]        rgn_valid,
    input  logic [NREG*AW-1:0]     rgn_lo,
    input  logic [NREG*AW-1:0]     rgn_hi,
    input  logic [NREG*PERM_W-1:0] rgn_perm,
    input  logic [NREG*PIDW-1:0]   rgn_pid,
    input  logic [NREG*PIDW-1:0]   rgn_pmask,
    input  logic                   acc_vld,
    input  logic [AW-1:0]          acc_addr,
    input  logic [MST_W-1:0]       acc_mst,
    input  logic [1:0]             acc_kind,
    input  logic                   acc_sup,
    input  logic [PIDW-1:0]        acc_pid,
    input  logic [PORTW-1:0]       acc_port,
    output logic                   grant,
    input  logic [NPORT-1:0]       err_clr,
    output logic [NPORT-1:0]       err_flag,
    output logic [NPORT*MST_W-1:0] err_mst,
    output logic [NPORT*AW-1:0]    err_addr,
    output logic [NPORT-1:0]       err_wr,
    output logic [NPORT*2-1:0]     err_attr,
    output logic [NPORT*2-1:0]     err_cls
);
    logic [NREG-1:0] hit_v, allow_v;
    logic            permit, refuse, multi;
    logic [1:0]      cls, attr;

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        region_match #(.AW(AW), .PIDW(PIDW)) u_match (
            .valid_i (rgn_valid[r]),
            .lo_i    (rgn_lo[r*AW +: AW]),
            .hi_i    (rgn_hi[r*AW +: AW]),
            .perm_i  (rgn_perm[r*PERM_W +: PERM_W]),
            .pid_i   (rgn_pid[r*PIDW +: PIDW]),
            .pmask_i (rgn_pmask[r*PIDW +: PIDW]),
            .addr_i  (acc_addr),
            .mst_i   (acc_mst),
            .kind_i  (acc_kind),
            .sup_i   (acc_sup),
            .apid_i  (acc_pid),
            .hit_o   (hit_v[r]),
            .allow_o (allow_v[r])
        );
    end

    // Merge region verdicts, classify a refusal and form its attribute.
    always_comb begin
        permit = |allow_v;
        grant  = acc_vld & (~glb_en | permit);
        refuse = acc_vld & glb_en & ~permit;
        multi  = (hit_v & (hit_v - 1'b1)) != '0;
        if (hit_v == '0) cls = CLS_NOHIT;
        else if (multi)  cls = CLS_OVERLAP;
        else             cls = CLS_SINGLE;
        attr = {acc_sup, acc_kind != KIND_EX};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fault_slot #(.AW(AW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (refuse && (acc_port == PORTW'(p))),
            .clr_i  (err_clr[p]),
            .mst_i  (acc_mst),
            .addr_i (acc_addr),
            .wr_i   (acc_kind == KIND_WR),
            .attr_i (attr),
            .cls_i  (cls),
            .flag_o (err_flag[p]),
            .mst_o  (err_mst[p*MST_W +: MST_W]),
            .addr_o (err_addr[p*AW +: AW]),
            .wr_o   (err_wr[p]),
            .attr_o (err_attr[p*2 +: 2]),
            .cls_o  (err_cls[p*2 +: 2])
        );
    end

    // R9
    nohit_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld && glb_en && hit_v == '0 |-> !grant);
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en && err_flag == '0 |=> err_flag == '0);
    // R7
    any_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld && allow_v != '0 |-> grant);
endmodule

// File: tb/region_guard_test.sv
// Bench: sweeps rights codes, bounds, identifiers, overlap and fault capture
// with expected values computed from the requirements.
module region_guard_test;
    localparam int NREG = 4, AW = 32, PIDW = 8, NPORT = 5, PORTW = 3, PW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, glb_en, acc_vld, acc_sup, grant;
    logic [NREG-1:0] rgn_valid;
    logic [NREG*AW-1:0] rgn_lo, rgn_hi;
    logic [NREG*PW-1:0] rgn_perm;
    logic [NREG*PIDW-1:0] rgn_pid, rgn_pmask;
    logic [AW-1:0] acc_addr;
    logic [2:0] acc_mst;
    logic [1:0] acc_kind;
    logic [PIDW-1:0] acc_pid;
    logic [PORTW-1:0] acc_port;
    logic [NPORT-1:0] err_clr, err_flag, err_wr;
    logic [NPORT*3-1:0] err_mst;
    logic [NPORT*AW-1:0] err_addr;
    logic [NPORT*2-1:0] err_attr, err_cls;

    int total = 0, fails = 0;

    region_guard uut (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] prv(int m, int u, int s, int pe);
        logic [PW-1:0] x = '0;
        x[m*6 +: 6] = {pe[0], s[1:0], u[2:0]};
        return x;
    endfunction

    function automatic logic [PW-1:0] pln(int m, int rwb);
        logic [PW-1:0] x = '0;
        x[24 + (m-4)*2 +: 2] = rwb[1:0];
        return x;
    endfunction

    function automatic bit exp_allow(int m, int kind, int sup, int u, int s, int rwb);
        int eff;
        if (m >= 4) begin
            if (kind == 2) return 0;
            return (rwb >> kind) & 1;
        end
        eff = u;
        if (sup != 0) begin
            if (s == 0) eff = 7;
            else if (s == 1) eff = 5;
            else if (s == 2) eff = 6;
        end
        return (eff >> (2 - kind)) & 1;
    endfunction

    task automatic put_rgn(int r, logic [AW-1:0] lo, logic [AW-1:0] hi,
                           logic [PW-1:0] perm, logic [7:0] pid, logic [7:0] msk, bit v);
        rgn_lo[r*AW +: AW] = lo;
        rgn_hi[r*AW +: AW] = hi;
        rgn_perm[r*PW +: PW] = perm;
        rgn_pid[r*PIDW +: PIDW] = pid;
        rgn_pmask[r*PIDW +: PIDW] = msk;
        rgn_valid[r] = v;
    endtask

    task automatic drive(int m, int kind, int sup, logic [7:0] pid, logic [AW-1:0] addr, int port);
        @(negedge clk);
        acc_vld = 1'b1; acc_mst = 3'(m); acc_kind = 2'(kind); acc_sup = sup[0];
        acc_pid = pid; acc_addr = addr; acc_port = 3'(port);
        #1;
    endtask

    initial begin
        #(200000 * 8);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 0; glb_en = 0; acc_vld = 0; acc_sup = 0; acc_mst = 0; acc_kind = 0;
        acc_pid = 0; acc_addr = 0; acc_port = 7; err_clr = '0;
        rgn_valid = '0; rgn_lo = '0; rgn_hi = '0; rgn_perm = '0; rgn_pid = '0; rgn_pmask = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "flags after reset", 64'(err_flag), 0);
        chk("R8", "grant without access", 64'(grant), 0);
        rst_n = 1; glb_en = 1;

        // R1 R2 R3: privileged masters, every user and supervisor code
        for (int m = 0; m < 4; m++)
            for (int u = 0; u < 8; u++)
                for (int s = 0; s < 4; s++)
                    for (int sp = 0; sp < 2; sp++)
                        for (int k = 0; k < 3; k++) begin
                            put_rgn(0, 32'h1013, 32'h1FE0, prv(m, u, s, 0), 0, 0, 1);
                            drive(m, k, sp, 8'h00, 32'h1400, 7);
                            chk(sp ? "R3" : "R2", "priv rights", 64'(grant),
                                64'(exp_allow(m, k, sp, u, s, 0)));
                        end
        // R4: plain masters
        for (int m = 4; m < 8; m++)
            for (int rwb = 0; rwb < 4; rwb++)
                for (int sp = 0; sp < 2; sp++)
                    for (int k = 0; k < 3; k++) begin
                        put_rgn(0, 32'h1013, 32'h1FE0, pln(m, rwb), 0, 0, 1);
                        drive(m, k, sp, 8'h00, 32'h1400, 7);
                        chk("R4", "plain rights", 64'(grant), 64'(exp_allow(m, k, sp, 0, 0, rwb)));
                    end
        // R1 and R9: bound edges
        put_rgn(0, 32'h1013, 32'h1FE0, prv(0, 7, 0, 0), 0, 0, 1);
        drive(0, 0, 0, 0, 32'h0FFF, 7); chk("R9", "below lower bound", 64'(grant), 0);
        drive(0, 0, 0, 0, 32'h1000, 7); chk("R1", "aligned lower bound", 64'(grant), 1);
        drive(0, 0, 0, 0, 32'h1FFF, 7); chk("R1", "aligned upper bound", 64'(grant), 1);
        drive(0, 0, 0, 0, 32'h2000, 7); chk("R9", "above upper bound", 64'(grant), 0);
        // R5: identifier compare under mask
        put_rgn(0, 32'h1000, 32'h1FFF, prv(1, 7, 3, 1), 8'h5A, 8'h0F, 1);
        drive(1, 0, 0, 8'h53, 32'h1100, 7); chk("R5", "masked id match", 64'(grant), 1);
        drive(1, 0, 0, 8'h6A, 32'h1100, 7); chk("R5", "id mismatch", 64'(grant), 0);
        put_rgn(0, 32'h1000, 32'h1FFF, prv(1, 7, 3, 0), 8'h5A, 8'h0F, 1);
        drive(1, 0, 0, 8'h6A, 32'h1100, 7); chk("R5", "id compare off", 64'(grant), 1);
        // R6: cleared valid bit
        put_rgn(0, 32'h1000, 32'h1FFF, prv(0, 7, 0, 0), 0, 0, 0);
        drive(0, 0, 0, 0, 32'h1100, 7); chk("R6", "invalid region", 64'(grant), 0);
        // R7: overlap, one permissive region wins
        put_rgn(0, 32'h3000, 32'h3FFF, prv(0, 0, 3, 0), 0, 0, 1);
        put_rgn(1, 32'h3000, 32'h3FFF, prv(0, 7, 3, 0), 0, 0, 1);
        drive(0, 1, 1, 0, 32'h3010, 7); chk("R7", "overlap one allows", 64'(grant), 1);
        // R8: global enable clear
        glb_en = 0;
        drive(6, 2, 0, 0, 32'h9000, 0); chk("R8", "grant when disabled", 64'(grant), 1);
        @(posedge clk); #1;
        chk("R8", "no capture when disabled", 64'(err_flag), 0);
        glb_en = 1;

        // Capture tests: clear all ports first
        @(negedge clk); acc_vld = 0; err_clr = '1;
        @(negedge clk); err_clr = '0;
        chk("R12", "all cleared", 64'(err_flag), 0);
        // R11 class 2 on port 1
        put_rgn(1, 32'h3000, 32'h3FFF, prv(0, 0, 3, 0), 0, 0, 1);
        drive(0, 1, 1, 0, 32'h3010, 1);
        chk("R7", "overlap all refuse", 64'(grant), 0);
        @(posedge clk); #1;
        chk("R13", "only port 1 flagged", 64'(err_flag), 64'h02);
        chk("R11", "overlap class", 64'(err_cls[2 +: 2]), 2);
        chk("R10", "sup data attr", 64'(err_attr[2 +: 2]), 3);
        chk("R10", "write flag", 64'(err_wr[1]), 1);
        chk("R10", "master", 64'(err_mst[3 +: 3]), 0);
        chk("R10", "address", 64'(err_addr[AW +: AW]), 64'h3010);
        // single-region refusal on port 2
        put_rgn(1, 0, 0, 0, 0, 0, 0);
        put_rgn(0, 32'h1000, 32'h1FFF, prv(2, 4, 3, 0) | prv(3, 0, 3, 0), 0, 0, 1);
        drive(2, 1, 0, 0, 32'h1234, 2);
        @(posedge clk); #1;
        chk("R11", "single class", 64'(err_cls[4 +: 2]), 1);
        chk("R10", "user data attr", 64'(err_attr[4 +: 2]), 1);
        chk("R10", "master p2", 64'(err_mst[6 +: 3]), 2);
        chk("R10", "address p2", 64'(err_addr[2*AW +: AW]), 64'h1234);
        // R12: second fault on port 2 ignored
        drive(5, 2, 1, 0, 32'h8000, 2);
        @(posedge clk); #1;
        chk("R12", "held address", 64'(err_addr[2*AW +: AW]), 64'h1234);
        chk("R12", "held master", 64'(err_mst[6 +: 3]), 2);
        // R13: same fault on port 4
        drive(5, 2, 1, 0, 32'h8000, 4);
        @(posedge clk); #1;
        chk("R13", "port 4 flagged", 64'(err_flag), 64'h16);
        chk("R11", "no-hit class", 64'(err_cls[8 +: 2]), 0);
        chk("R10", "sup instr attr", 64'(err_attr[8 +: 2]), 2);
        chk("R10", "execute not write", 64'(err_wr[4]), 0);
        chk("R10", "master p4", 64'(err_mst[12 +: 3]), 5);
        // R12: clear wins over same-cycle fault
        drive(3, 2, 0, 0, 32'h1100, 2);
        err_clr = 5'b00100;
        @(posedge clk); #1;
        err_clr = '0;
        chk("R12", "clear beats fault", 64'(err_flag[2]), 0);
        drive(3, 2, 0, 0, 32'h1100, 2);
        @(posedge clk); #1;
        chk("R12", "recapture after clear", 64'(err_flag[2]), 1);
        chk("R10", "user instr attr", 64'(err_attr[4 +: 2]), 0);
        chk("R10", "recaptured address", 64'(err_addr[2*AW +: AW]), 64'h1100);
        chk("R10", "recaptured master", 64'(err_mst[6 +: 3]), 3);
        @(negedge clk); acc_vld = 0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule